// File: doc/BRIEF.md
# Firmware-Stepped I2C Slave Receiver

This block is the receive datapath of an I2C slave in which firmware drives each phase of the transfer. Firmware pulses a trigger and gives a 3-bit operation code. The code selects one of two phases: take in one data byte, or answer the master with an ACK or NAK bit. The block synchronises the bus lines to the system clock. It samples SDA on each rising edge of SCL, most significant bit first, and moves each completed byte into a receive register. At the end of every phase it reports the result through a 3-bit status code and a one-cycle interrupt pulse.

Between phases the block stretches the clock. Once a byte has arrived, or once the acknowledge bit has gone out, it holds SCL low as soon as the master lets SCL fall. It keeps holding SCL until firmware triggers the next phase. If the master issues a stop condition in the middle of a byte, the block drops that byte and reports the stop. Both bus outputs are open-drain pull enables and are active low, so a 0 pulls the wire down.

Top module: `i2c_step_rx`

## Requirements
- R1: While reset is held and just after it is released: busy is 0, status is 0, irq is 0, rx_data is 0, and both scl_pull_n and sda_pull_n are 1.
- R2: While the block is idle, a trigger with op_code 3 (receive), 4 (ACK) or 5 (NAK) sets busy in the next cycle. A trigger with any other op_code is ignored: busy stays 0, and any clock stretch in progress continues.
- R3: During a receive phase, SDA is sampled on each rising SCL edge, first bit to the MSB. After the 8th rising edge, rx_data holds the byte, status becomes 3, busy falls, and irq pulses.
- R4: After a byte has been received, scl_pull_n is 0 while SCL is low, so the line stays low even when the master releases it, until the next accepted trigger.
- R5: An ACK phase (op 4) drives sda_pull_n to 0 from the trigger until the falling SCL edge that follows the next rising edge. It then releases SDA, sets status to 4, clears busy and pulses irq.
- R6: A NAK phase (op 5) keeps sda_pull_n at 1 for the whole acknowledge clock, then sets status to 4, clears busy and pulses irq.
- R7: After an ACK or NAK phase ends, SCL is stretched low until the next accepted trigger.
- R8: A stop condition (SDA rising while SCL is high) during a receive phase ends it. Status becomes 1, busy falls, irq pulses, rx_data keeps its previous byte, and SCL is not stretched.
- R9: A trigger given while busy is ignored. It does not change the phase in progress or the outputs.
- R10: irq is high for exactly one cycle, and only in the cycle in which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Sensed SCL wire level |
| sda_in | input | 1 | Sensed SDA wire level |
| trig | input | 1 | Firmware phase trigger, one cycle |
| op_code | input | 3 | Phase select: 3 receive, 4 ACK, 5 NAK |
| scl_pull_n | output | 1 | Pull SCL low when 0 (clock stretch) |
| sda_pull_n | output | 1 | Pull SDA low when 0 (ACK bit) |
| busy | output | 1 | A phase is in progress |
| status | output | 3 | 0 none, 1 stop seen, 3 byte received, 4 ACK/NAK sent |
| rx_data | output | 8 | Last byte received |
| irq | output | 1 | One-cycle pulse at the end of a phase |

## Verification
The assertions rely on the master changing SDA only while SCL is low, except when it forms a start or stop. They also rely on each SCL level lasting well beyond the two-flop synchroniser delay, so that the block never sees an SCL edge and a trigger in the same cycle. The bench master holds each SCL half period for sixteen clocks and sets SDA in the middle of the low phase. It waits for the wire, not its own drive, before it times the high phase, and so obeys the stretch. Firmware triggers come only while the master has SCL low.

// File: rtl/i2c_step_pkg.sv
// Shared codes for the firmware-stepped I2C slave receiver.
// Assumes: op and status codes are 3 bits wide.
package i2c_step_pkg;
    localparam logic [2:0] OP_RECV = 3'd3;
    localparam logic [2:0] OP_ACK  = 3'd4;
    localparam logic [2:0] OP_NAK  = 3'd5;

    localparam logic [2:0] ST_NONE    = 3'd0;
    localparam logic [2:0] ST_STOP    = 3'd1;
    localparam logic [2:0] ST_RXDONE  = 3'd3;
    localparam logic [2:0] ST_ACKDONE = 3'd4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RECV,
        PH_ACK_LOW,
        PH_ACK_HIGH
    } phase_t;
endpackage

// File: rtl/i2c_step_sync.sv
// Multi-stage synchroniser for asynchronous bus inputs.
// Assumes: inputs idle high, so every stage resets to 1.
module i2c_step_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the sampled levels one stage down the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)      stage_q[s] <= '1;
            else if (s == 0) stage_q[s] <= d;
            else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_step_events.sv
// Finds SCL edges and stop conditions on synchronised bus levels.
// Assumes: inputs are already synchronous to clk.
module i2c_step_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic stop_seen
);
    logic scl_d, sda_d;

    // Keep last cycle's levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign stop_seen = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/i2c_step_shift.sv
// Bit collector: shifts sampled bits in MSB first and flags the last one.
// Assumes: clear and sample are never high in the same cycle.
module i2c_step_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word,
    output logic              last
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    logic [DATA_W-2:0] shreg;
    logic [CNT_W-1:0]  cnt;

    // Collect bits and count how many have arrived in this byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (sample) begin
            shreg <= {shreg[DATA_W-3:0], bit_in};
            cnt   <= cnt + 1'b1;
        end
    end

    assign word = {shreg, bit_in};
    assign last = sample && (cnt == CNT_W'(DATA_W - 1));
endmodule

// File: rtl/i2c_step_rx.sv
// Firmware-stepped I2C slave receiver: each receive or acknowledge
// phase starts on a trigger, reports status and irq, and SCL is
// stretched between phases.
// Assumes: SCL levels last much longer than the synchroniser delay.
module i2c_step_rx
    import i2c_step_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              trig,
    input  logic [2:0]        op_code,
    output logic              scl_pull_n,
    output logic              sda_pull_n,
    output logic              busy,
    output logic [2:0]        status,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq
);
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, stop_seen;
    logic [DATA_W-1:0] word;
    logic last_bit, start_rx, sample;

    phase_t            phase_q;
    logic              busy_q, irq_q, hold_q, sda_drv_q;
    logic [2:0]        status_q;
    logic [DATA_W-1:0] rx_q;

    i2c_step_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    i2c_step_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .stop_seen (stop_seen)
    );

    assign start_rx = (phase_q == PH_IDLE) && trig && (op_code == OP_RECV);
    assign sample   = (phase_q == PH_RECV) && scl_rise;

    i2c_step_shift #(.DATA_W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_rx),
        .sample (sample),
        .bit_in (sda_s),
        .word   (word),
        .last   (last_bit)
    );

    // Phase sequencer: accepts triggers when idle and closes each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            busy_q    <= 1'b0;
            irq_q     <= 1'b0;
            hold_q    <= 1'b0;
            sda_drv_q <= 1'b0;
            status_q  <= ST_NONE;
            rx_q      <= '0;
        end else begin
            irq_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (trig && op_code == OP_RECV) begin
                        phase_q <= PH_RECV;
                        busy_q  <= 1'b1;
                        hold_q  <= 1'b0;
                    end else if (trig && (op_code == OP_ACK || op_code == OP_NAK)) begin
                        phase_q   <= PH_ACK_LOW;
                        busy_q    <= 1'b1;
                        hold_q    <= 1'b0;
                        sda_drv_q <= (op_code == OP_ACK);
                    end
                end
                PH_RECV: begin
                    if (stop_seen) begin
                        phase_q  <= PH_IDLE;
                        busy_q   <= 1'b0;
                        irq_q    <= 1'b1;
                        status_q <= ST_STOP;
                    end else if (last_bit) begin
                        phase_q  <= PH_IDLE;
                        busy_q   <= 1'b0;
                        irq_q    <= 1'b1;
                        hold_q   <= 1'b1;
                        status_q <= ST_RXDONE;
                        rx_q     <= word;
                    end
                end
                PH_ACK_LOW: begin
                    if (scl_rise) phase_q <= PH_ACK_HIGH;
                end
                PH_ACK_HIGH: begin
                    if (scl_fall) begin
                        phase_q   <= PH_IDLE;
                        busy_q    <= 1'b0;
                        irq_q     <= 1'b1;
                        hold_q    <= 1'b1;
                        sda_drv_q <= 1'b0;
                        status_q  <= ST_ACKDONE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign scl_pull_n = ~(hold_q & ~scl_s);
    assign sda_pull_n = ~sda_drv_q;
    assign busy       = busy_q;
    assign irq        = irq_q;
    assign status     = status_q;
    assign rx_data    = rx_q;
endmodule

// File: rtl/i2c_step_rx_chk.sv
// Property checker for i2c_step_rx, attached by bind.
// Assumes: it sees the top-level ports only.
module i2c_step_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic [2:0]        op_code,
    input logic              scl_pull_n,
    input logic              sda_pull_n,
    input logic              busy,
    input logic [2:0]        status,
    input logic [DATA_W-1:0] rx_data,
    input logic              irq
);
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r10_irq_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    a_r2_busy_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(trig) && ($past(op_code) inside {3'd3, 3'd4, 3'd5})));

    a_r5_sda_drive_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_pull_n |-> busy);

    a_r4_stretch_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_pull_n |-> !busy);

    a_r3_irq_status_valid: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status inside {3'd1, 3'd3, 3'd4}));

    a_r8_stop_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && status == 3'd1) |-> (scl_pull_n && $stable(rx_data)));
endmodule

bind i2c_step_rx i2c_step_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .op_code    (op_code),
    .scl_pull_n (scl_pull_n),
    .sda_pull_n (sda_pull_n),
    .busy       (busy),
    .status     (status),
    .rx_data    (rx_data),
    .irq        (irq)
);

// File: tb/tb_i2c_step_rx.sv
module tb_i2c_step_rx;
    localparam int CLK_P    = 10;
    localparam int HALF     = 16;
    localparam int WD_LIMIT = 100000;
    localparam int NVEC     = 6;
    // {byte, 1 = answer ACK / 0 = answer NAK}
    localparam logic [8:0] VEC [NVEC] = '{
        {8'hA5, 1'b1}, {8'h00, 1'b0}, {8'hFF, 1'b1},
        {8'h3C, 1'b1}, {8'h81, 1'b0}, {8'h5A, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       trig = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic       scl_pull_n, sda_pull_n, busy, irq;
    logic [2:0] status;
    logic [7:0] rx_data;
    logic       scl_line, sda_line;
    int         tests = 0, fails = 0, irq_cnt = 0, cycles = 0;
    bit         done = 1'b0;

    assign scl_line = m_scl & scl_pull_n;
    assign sda_line = m_sda & sda_pull_n;

    always #(CLK_P/2) clk = ~clk;

    i2c_step_rx dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .trig(trig), .op_code(op_code), .scl_pull_n(scl_pull_n),
        .sda_pull_n(sda_pull_n), .busy(busy), .status(status),
        .rx_data(rx_data), .irq(irq)
    );

    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fw_go(input logic [2:0] op);
        @(negedge clk);
        trig = 1'b1; op_code = op;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic scl_pulse();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        wait_clk(HALF);
        m_scl = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;
        wait_clk(HALF);
        scl_pulse();
    endtask

    initial begin
        // Watchdog: an expired run counts as a failure.
        while (!done && cycles < WD_LIMIT) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] prev;
        wait_clk(5);
        chk(busy == 0 && irq == 0 && scl_pull_n && sda_pull_n, "R1 in reset", {busy, irq, scl_pull_n, sda_pull_n}, 4'b0011);
        rst_n = 1'b1;
        wait_clk(3);
        chk(status == 0 && rx_data == 0 && busy == 0, "R1 after reset", {status, rx_data}, 0);
        chk(scl_pull_n && sda_pull_n, "R1 pulls released", {scl_pull_n, sda_pull_n}, 2'b11);

        // R2: unsupported codes when idle
        fw_go(3'd0); wait_clk(3);
        chk(busy == 0, "R2 op 0 ignored", busy, 0);
        fw_go(3'd7); wait_clk(3);
        chk(busy == 0, "R2 op 7 ignored", busy, 0);

        // start condition
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b0; wait_clk(HALF);

        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] b;
            logic ack;
            b = VEC[i][8:1]; ack = VEC[i][0];
            base = irq_cnt;
            fw_go(3'd3); wait_clk(1);
            chk(busy == 1, "R2 receive trigger sets busy", busy, 1);
            for (int k = 7; k >= 0; k--) send_bit(b[k]);
            chk(rx_data == b, "R3 byte value", rx_data, b);
            chk(status == 3 && busy == 0, "R3 status and busy", {status, busy}, {3'd3, 1'b0});
            chk(irq_cnt == base + 1, "R10 one irq per byte", irq_cnt, base + 1);
            chk(scl_pull_n == 0, "R4 stretch after byte", scl_pull_n, 0);
            if (i == 0) begin
                m_scl = 1'b1; wait_clk(10);
                chk(scl_line == 0, "R4 line held low", scl_line, 0);
                m_scl = 1'b0; wait_clk(4);
            end
            fw_go(ack ? 3'd4 : 3'd5);
            m_sda = 1'b1;
            wait_clk(4);
            chk(scl_pull_n == 1, "R7 stretch released by trigger", scl_pull_n, 1);
            if (ack) chk(sda_line == 0, "R5 ACK drives SDA low", sda_line, 0);
            else     chk(sda_line == 1, "R6 NAK leaves SDA high", sda_line, 1);
            wait_clk(HALF - 4);
            scl_pulse();
            chk(sda_pull_n == 1, "R5 SDA released after ack clock", sda_pull_n, 1);
            chk(status == 4 && busy == 0, "R5 R6 ack status", {status, busy}, {3'd4, 1'b0});
            chk(irq_cnt == base + 2, "R10 one irq per ack", irq_cnt, base + 2);
            chk(scl_pull_n == 0, "R7 stretch after ack", scl_pull_n, 0);
        end

        // R2: unsupported code while stretched keeps the stretch
        fw_go(3'd6); wait_clk(4);
        chk(scl_pull_n == 0 && busy == 0, "R2 op 6 keeps stretch", {scl_pull_n, busy}, 2'b00);

        // R9: trigger while busy is ignored
        fw_go(3'd3);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        fw_go(3'd4); wait_clk(4);
        chk(sda_pull_n == 1, "R9 ack trigger ignored while busy", sda_pull_n, 1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        chk(rx_data == 8'hC3, "R9 byte intact", rx_data, 8'hC3);
        fw_go(3'd4); m_sda = 1'b1; wait_clk(HALF);
        scl_pulse();

        // R8: stop in the middle of a byte
        prev = rx_data;
        base = irq_cnt;
        fw_go(3'd3);
        send_bit(1'b1); send_bit(1'b0);
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b1; wait_clk(6);
        chk(status == 1 && busy == 0, "R8 stop status", {status, busy}, {3'd1, 1'b0});
        chk(irq_cnt == base + 1, "R8 irq on stop", irq_cnt, base + 1);
        chk(rx_data == prev, "R8 rx_data kept", rx_data, prev);
        m_scl = 1'b0; wait_clk(6);
        chk(scl_pull_n == 1, "R8 no stretch after stop", scl_pull_n, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule